// File: doc/BRIEF.md
# Phase-Gated Shared Bus Bridge

This block sits between a processor core and a system bus that a video controller also masters. The core hands it one read or write at a time over a request/acknowledge handshake. The bridge then places the transfer on the shared bus. It times every step from the bus-enable phase input `aec`, which the video controller supplies from its bus-available output; the core's own clock does not set this timing. Address, data and the read/write line are driven only while that phase input is high. While it is low, all three driver enables are released so that the video controller can use the bus.

A read waits for a falling edge of the phase and then presents its address. It holds there while the ready input is low. Once ready is seen high, it completes at the next falling edge of the phase by capturing the data bus. A write also waits for a falling edge. It then drives address, write direction and data for one full high phase and lets go at the falling edge that ends that phase. Ready has no effect on writes. Both phase and ready pass through a multi-flop synchronizer before edges are detected.

The bridge also holds a small output port at a fixed address. A write there still goes out on the bus, and in the same step it loads three bank-select outputs. These outputs steer the BASIC-ROM window, the I/O-or-character window and the system-ROM window between ROM and RAM.

Top module: `shared_bus_bridge`

## Requirements
- R1: Whenever `aec` is low, `bus_addr_oe`, `bus_data_oe` and `bus_rw_oe` are all low in that same cycle.
- R2: After reset, `ack` is low, all three driver enables are low and `bank_sel` is 3'b111.
- R3: An accepted request drives nothing until a falling edge of `aec` has occurred. After that edge it drives `bus_addr_o` equal to the request address, and the address stays stable while driven. `bus_rw_o` is 1 for a read and 0 for a write.
- R4: A read stalls while `rdy` is low and does not acknowledge. Once `rdy` is high, the read ends at the next falling edge of `aec`. At that point `rdata` holds the value on `bus_data_i` and `ack` is raised.
- R5: A write drives `bus_data_o` equal to the request data with `bus_data_oe`, `bus_addr_oe` and `bus_rw_oe` high and `bus_rw_o` = 0. It ends with `ack` at the falling edge of `aec` that closes its drive phase, and `rdy` has no effect on it.
- R6: `ack` is high for exactly one clock cycle per completed transfer.
- R7: A write to address 16'h0001 loads `bank_sel[2:0]` from write data bits [2:0] in the cycle `ack` rises. Bit 0 selects the BASIC-ROM window, bit 1 the system-ROM window and bit 2 the character/I-O window. Reads and writes to any other address leave `bank_sel` unchanged.
- R8: A write to 16'h0001 is also carried out on the shared bus like any other write.
- R9: A request raised while a transfer is in flight is ignored: it produces no acknowledge and no bus activity of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core request strobe, taken when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| aec | input | 1 | Bus-enable phase from the video controller |
| rdy | input | 1 | Ready; low stalls reads |
| bus_addr_o | output | ADDR_W | Address driver value |
| bus_addr_oe | output | 1 | Address driver enable |
| bus_data_o | output | DATA_W | Data driver value |
| bus_data_i | input | DATA_W | Data bus input |
| bus_data_oe | output | 1 | Data driver enable (direction) |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_rw_oe | output | 1 | Read/write driver enable |
| bank_sel | output | 3 | Bank-select port outputs |

## Verification
Reads are swept over many addresses, and the bus model returns a value computed from the address. This tells a correct capture apart from a stale or mis-timed one. Writes to the port address use all eight low-bit patterns with varied upper bits, which confirms that only bits [2:0] are loaded. Writes and reads to other addresses show the port is left alone. Holding ready low during a read and then during a write shows that the stall applies only to reads. A second request injected mid-transfer shows the busy bridge ignores it.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ALIGN,
      ST_RD_ADDR,
      ST_RD_SAMPLE,
      ST_WR_ALIGN,
      ST_WR_DRIVE
   } sbb_state_e;

   localparam int SBB_BANK_BITS = 3;

endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sbb_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sbb_seq.sv
module sbb_seq
   import sbb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              aec_s,
   input  logic              rdy_s,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              drv_addr,
   output logic              drv_data,
   output logic              rw_level,
   output logic              wr_done
);

   sbb_state_e state;
   logic       aec_q;
   logic       aec_fall;

   assign aec_fall = aec_q & ~aec_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aec_q <= 1'b0;
      else        aec_q <= aec_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ack       <= 1'b0;
         rdata     <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else begin
         ack <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  cur_addr  <= req_addr;
                  cur_wdata <= req_wdata;
                  state     <= req_we ? ST_WR_ALIGN : ST_RD_ALIGN;
               end
            end
            ST_RD_ALIGN:  if (aec_fall) state <= ST_RD_ADDR;
            ST_RD_ADDR:   if (rdy_s)    state <= ST_RD_SAMPLE;
            ST_RD_SAMPLE: begin
               if (aec_fall) begin
                  rdata <= bus_data_i;
                  ack   <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_WR_ALIGN:  if (aec_fall) state <= ST_WR_DRIVE;
            ST_WR_DRIVE: begin
               if (aec_fall) begin
                  ack   <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      drv_addr = (state == ST_RD_ADDR) || (state == ST_RD_SAMPLE) || (state == ST_WR_DRIVE);
      drv_data = (state == ST_WR_DRIVE);
      rw_level = (state != ST_WR_DRIVE);
      wr_done  = (state == ST_WR_DRIVE) && aec_fall;
   end

endmodule

// File: rtl/sbb_bank_port.sv
module sbb_bank_port #(
   parameter int                   ADDR_W    = 16,
   parameter int                   BITS      = 3,
   parameter logic [ADDR_W-1:0]    PORT_ADDR = 16'h0001,
   parameter logic [BITS-1:0]      RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_done,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BITS-1:0]   wr_bits,
   output logic [BITS-1:0]   bank
);

   logic hit;
   assign hit = wr_done && (wr_addr == PORT_ADDR);

   generate
      for (genvar b = 0; b < BITS; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank[b] <= RESET_VAL[b];
            else if (hit) bank[b] <= wr_bits[b];
         end
      end
   endgenerate

endmodule

// File: rtl/shared_bus_bridge.sv
module shared_bus_bridge
   import sbb_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'h0001
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req,
   input  logic                     req_we,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     ack,
   output logic [DATA_W-1:0]        rdata,
   input  logic                     aec,
   input  logic                     rdy,
   output logic [ADDR_W-1:0]        bus_addr_o,
   output logic                     bus_addr_oe,
   output logic [DATA_W-1:0]        bus_data_o,
   input  logic [DATA_W-1:0]        bus_data_i,
   output logic                     bus_data_oe,
   output logic                     bus_rw_o,
   output logic                     bus_rw_oe,
   output logic [SBB_BANK_BITS-1:0] bank_sel
);

   generate
      if (DATA_W < SBB_BANK_BITS) begin : g_bad_data
         $error("shared_bus_bridge: DATA_W too narrow for bank port");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("shared_bus_bridge: ADDR_W too narrow");
      end
   endgenerate

   logic [1:0]        raw_in;
   logic [1:0]        syn_out;
   logic              drv_addr, drv_data, rw_level, wr_done;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;

   assign raw_in = {rdy, aec};

   sbb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (syn_out)
   );

   sbb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .aec_s     (syn_out[0]),
      .rdy_s     (syn_out[1]),
      .bus_data_i(bus_data_i),
      .ack       (ack),
      .rdata     (rdata),
      .cur_addr  (cur_addr),
      .cur_wdata (cur_wdata),
      .drv_addr  (drv_addr),
      .drv_data  (drv_data),
      .rw_level  (rw_level),
      .wr_done   (wr_done)
   );

   sbb_bank_port #(
      .ADDR_W   (ADDR_W),
      .BITS     (SBB_BANK_BITS),
      .PORT_ADDR(PORT_ADDR),
      .RESET_VAL('1)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_done(wr_done),
      .wr_addr(cur_addr),
      .wr_bits(cur_wdata[SBB_BANK_BITS-1:0]),
      .bank   (bank_sel)
   );

   // Raw phase input gates the enables so release does not wait for the synchronizer.
   assign bus_addr_o  = cur_addr;
   assign bus_data_o  = cur_wdata;
   assign bus_rw_o    = rw_level;
   assign bus_addr_oe = drv_addr & aec;
   assign bus_rw_oe   = drv_addr & aec;
   assign bus_data_oe = drv_data & aec;

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              aec,
   input logic              ack,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_addr_oe,
   input logic              bus_data_oe,
   input logic              bus_rw_o,
   input logic              bus_rw_oe,
   input logic [2:0]        bank_sel
);

   assert_float_when_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !aec |-> !(bus_addr_oe || bus_data_oe || bus_rw_oe));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_oe && $past(bus_addr_oe)) |-> $stable(bus_addr_o));

   assert_read_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rw_oe && !bus_data_oe) |-> bus_rw_o);

   assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> (bus_addr_oe && bus_rw_oe && !bus_rw_o));

   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   assert_bank_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_sel) |-> ack);

endmodule

bind shared_bus_bridge sbb_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .aec        (aec),
   .ack        (ack),
   .bus_addr_o (bus_addr_o),
   .bus_addr_oe(bus_addr_oe),
   .bus_data_oe(bus_data_oe),
   .bus_rw_o   (bus_rw_o),
   .bus_rw_oe  (bus_rw_oe),
   .bank_sel   (bank_sel)
);

// File: tb/sim_shared_bus_bridge.sv
`timescale 1ns/1ps
module sim_shared_bus_bridge;

   localparam int AEC_HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ack;
   logic [7:0]  rdata;
   logic        aec = 1'b1;
   logic        rdy = 1'b1;
   logic [15:0] bus_addr_o;
   logic        bus_addr_oe;
   logic [7:0]  bus_data_o;
   logic [7:0]  bus_data_i;
   logic        bus_data_oe;
   logic        bus_rw_o;
   logic        bus_rw_oe;
   logic [2:0]  bank_sel;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   shared_bus_bridge u0 (.*);

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction

   // bus model and monitors
   logic [15:0] last_addr = '0;
   logic [15:0] exp_addr = '0;
   logic        exp_we = 1'b0;
   logic        aec_d = 1'b1;
   logic        ack_d = 1'b0;
   int          fall_cnt = 0, drive_cnt = 0, ack_cnt = 0, bus_err = 0;
   int          float_err = 0, ack_dbl = 0, wr_cnt = 0;
   logic [15:0] wr_addr_seen = '0;
   logic [7:0]  wr_data_seen = '0;

   assign bus_data_i = pat(last_addr);

   always @(negedge clk) begin
      aec_d <= aec;
      ack_d <= ack;
      if (aec_d && !aec) fall_cnt <= fall_cnt + 1;
      if (ack) ack_cnt <= ack_cnt + 1;
      if (ack && ack_d) ack_dbl <= ack_dbl + 1;
      if (!aec && (bus_addr_oe || bus_data_oe || bus_rw_oe)) float_err <= float_err + 1;
      if (bus_addr_oe) begin
         last_addr <= bus_addr_o;
         drive_cnt <= drive_cnt + 1;
         if (bus_addr_o != exp_addr || bus_rw_o != !exp_we) bus_err <= bus_err + 1;
      end
      if (bus_data_oe) begin
         wr_cnt       <= wr_cnt + 1;
         wr_addr_seen <= bus_addr_o;
         wr_data_seen <= bus_data_o;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
      end
   endtask

   task automatic pulse_req(input logic we, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_ack(input int base, input int limit);
      int n = 0;
      while (ack_cnt == base && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic txn(input logic we, input logic [15:0] a, input logic [7:0] d);
      int f0, dr0, ac0, be0, wc0, n;
      exp_addr = a; exp_we = we;
      @(negedge clk);
      f0 = fall_cnt; dr0 = drive_cnt; ac0 = ack_cnt; be0 = bus_err; wc0 = wr_cnt;
      pulse_req(we, a, d);
      n = 0;
      while (fall_cnt == f0 && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(drive_cnt == dr0, "R3 no drive before phase fall", drive_cnt - dr0, 0);
      wait_ack(ac0, 400);
      chk(ack_cnt == ac0 + 1, we ? "R5 write ack" : "R4 read ack", ack_cnt - ac0, 1);
      chk(bus_err == be0, "R3 address/rw on bus", bus_err - be0, 0);
      if (we) begin
         chk(wr_cnt > wc0 && wr_addr_seen == a && wr_data_seen == d,
             "R5 write data on bus", {wr_addr_seen, wr_data_seen}, {a, d});
      end else begin
         chk(rdata == pat(a), "R4 read data", rdata, pat(a));
      end
   endtask

   // phase generator
   initial begin
      forever begin
         repeat (AEC_HALF) @(negedge clk);
         aec = ~aec;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] bank_before;
      int ac0, dr0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(ack == 1'b0, "R2 ack after reset", ack, 0);
      chk(!(bus_addr_oe || bus_data_oe || bus_rw_oe), "R2 enables after reset",
          {bus_addr_oe, bus_data_oe, bus_rw_oe}, 0);
      chk(bank_sel == 3'b111, "R2 bank after reset", bank_sel, 7);

      // R3/R4 read sweep
      for (int i = 0; i < 16; i++) begin
         txn(1'b0, 16'(i * 16'h1111 + 16'h0203), 8'h00);
      end

      // R7/R8 port writes over all low-bit patterns
      for (int v = 0; v < 8; v++) begin
         txn(1'b1, 16'h0001, 8'((v * 8'h29) & 8'hF8) | 8'(v));
         chk(bank_sel == 3'(v), "R7 bank loads low bits", bank_sel, v);
      end

      // R7 other addresses and reads leave bank alone
      bank_before = bank_sel;
      txn(1'b1, 16'h0000, 8'h02);
      txn(1'b1, 16'h0101, 8'h05);
      txn(1'b0, 16'h0001, 8'h00);
      chk(bank_sel == bank_before, "R7 bank unchanged by others", bank_sel, bank_before);

      // R5 plain writes
      txn(1'b1, 16'hD020, 8'h0E);
      txn(1'b1, 16'hFFFF, 8'hA5);

      // R4 read stall on rdy
      rdy = 1'b0;
      exp_addr = 16'h0400; exp_we = 1'b0;
      @(negedge clk);
      ac0 = ack_cnt; dr0 = drive_cnt;
      pulse_req(1'b0, 16'h0400, 8'h00);
      repeat (12 * AEC_HALF) @(negedge clk);
      chk(ack_cnt == ac0, "R4 no ack while rdy low", ack_cnt - ac0, 0);
      chk(drive_cnt > dr0, "R3 address driven during stall", drive_cnt - dr0, 1);
      rdy = 1'b1;
      wait_ack(ac0, 400);
      chk(ack_cnt == ac0 + 1, "R4 ack after rdy high", ack_cnt - ac0, 1);
      chk(rdata == pat(16'h0400), "R4 stalled read data", rdata, pat(16'h0400));

      // R5 write ignores rdy
      rdy = 1'b0;
      txn(1'b1, 16'h0001, 8'h03);
      chk(bank_sel == 3'b011, "R7 bank with rdy low", bank_sel, 3);
      rdy = 1'b1;

      // R9 request while busy ignored
      bank_before = bank_sel;
      exp_addr = 16'h1234; exp_we = 1'b0;
      @(negedge clk);
      ac0 = ack_cnt;
      pulse_req(1'b0, 16'h1234, 8'h00);
      repeat (4) @(negedge clk);
      pulse_req(1'b1, 16'h0001, 8'h04);
      wait_ack(ac0, 400);
      chk(rdata == pat(16'h1234), "R9 first request completes", rdata, pat(16'h1234));
      repeat (8 * AEC_HALF) @(negedge clk);
      chk(ack_cnt == ac0 + 1, "R9 busy request ignored", ack_cnt - ac0, 1);
      chk(bank_sel == bank_before, "R9 bank untouched by ignored write", bank_sel, bank_before);

      chk(float_err == 0, "R1 drivers released while aec low", float_err, 0);
      chk(ack_dbl == 0, "R6 ack single cycle", ack_dbl, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule